// File: doc/BRIEF.md
# Register Bus Target Interface

This block is the target end of a simple configuration bus. A host sends one-word requests over a valid/ready channel. Each request carries a 16-bit byte address, 32 bits of write data, a write flag and a non-posted flag. The block serves every request from a small internal register file.

Read data goes back on a return channel that carries only a valid signal and a data word. Write completions go back on a single pulse line. The host cannot stall either return channel. A posted write updates the register and returns nothing. A non-posted write updates the register and returns one completion pulse.

While a read response or a write completion is being issued, the target lowers ready. At most one response is therefore ever pending, so responses always leave in the order the requests arrived. Host and target share one clock. An address that is misaligned, or that lies beyond the last implemented register, is an error: writes to it are discarded, and reads of it return zero.

Top module: `regbus_target`

## Requirements
- R1: While `rst_n` is low at a clock edge, all registers clear to zero. After that edge, `req_ready` is 1 and both `rsp_rd_valid` and `rsp_wr_done` are 0.
- R2: A request is taken only at an edge where `req_valid` and `req_ready` are both 1. A request presented while `req_ready` is 0 changes no register and produces no response.
- R3: A request with `req_write`=0 is a read. In the cycle after it is taken, `rsp_rd_valid` is 1 for exactly one cycle and `rsp_rd_data` holds the addressed register.
- R4: A request with `req_write`=1 and `req_nposted`=0 is a posted write. It stores all 32 data bits. No `rsp_wr_done` follows it, and `req_ready` stays 1 in the next cycle.
- R5: A request with `req_write`=1 and `req_nposted`=1 is a non-posted write. It stores the data. In the cycle after it is taken, `rsp_wr_done` is 1 for exactly one cycle and `req_ready` is 0. In the cycle after that, `req_ready` returns to 1.
- R6: `req_ready` is 0 in every cycle in which `rsp_rd_valid` or `rsp_wr_done` is 1. It returns to 1 in the following cycle.
- R7: Register k (0 ≤ k < NUM_REGS) sits at byte address 4·k. An address whose two low bits are not 00, or whose word index is NUM_REGS or more, is unmapped. A write to an unmapped address changes no register. A read of an unmapped address still gets its single response, with data zero.
- R8: `rsp_rd_valid` and `rsp_wr_done` are never 1 in the same cycle, and each response follows exactly one taken request.
- R9: Registers are independent: a write to one index leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by host and target |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Target can take a request this cycle |
| req_addr | input | 16 | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nposted | input | 1 | 1 = non-posted write (completion wanted), 0 = posted |
| rsp_rd_valid | output | 1 | Read response valid, one cycle |
| rsp_rd_data | output | 32 | Read response data, zero on error |
| rsp_wr_done | output | 1 | Completion pulse for a non-posted write |

## Verification
The hardest case to reach from the ports is a request that arrives during the single busy cycle after a read or a non-posted write. Only in that window is ready low, and the request has to be withdrawn before ready rises again. The bench raises valid with a write exactly in that window and drops it one cycle later. It then reads the target register back to show the write was never taken. A reset applied in the middle of the run, followed by read-back of registers that were written earlier, covers the clearing path.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int unsigned RB_ADDR_W = 16;
  localparam int unsigned RB_DATA_W = 32;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_PWR   = 2'd1,
    KIND_NPWR  = 2'd2
  } req_kind_e;

  // Address is mapped when word aligned and its word index is below nregs.
  function automatic logic addr_mapped(input logic [RB_ADDR_W-1:0] a,
                                       input int unsigned nregs);
    logic [31:0] widx;
    widx = 32'(a) >> 2;
    return (a[1:0] == 2'b00) && (widx < nregs);
  endfunction

  function automatic req_kind_e classify(input logic wr, input logic np);
    if (!wr)     return KIND_READ;
    else if (np) return KIND_NPWR;
    else         return KIND_PWR;
  endfunction
endpackage

// File: rtl/regbus_req_decode.sv
module regbus_req_decode
  import regbus_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 req_valid,
  input  logic                 req_ready,
  input  logic [RB_ADDR_W-1:0] req_addr,
  input  logic                 req_write,
  input  logic                 req_nposted,
  output logic                 accept,
  output logic                 rd_fire,
  output logic                 pw_fire,
  output logic                 npw_fire,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);
  req_kind_e kind;

  always_comb begin
    kind     = classify(req_write, req_nposted);
    accept   = req_valid && req_ready;
    hit      = addr_mapped(req_addr, NUM_REGS);
    idx      = req_addr[IDX_W+1:2];
    rd_fire  = accept && (kind == KIND_READ);
    pw_fire  = accept && (kind == KIND_PWR);
    npw_fire = accept && (kind == KIND_NPWR);
  end
endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile
  import regbus_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     idx,
  input  logic [RB_DATA_W-1:0] wdata,
  output logic [RB_DATA_W-1:0] rdata
);
  logic [RB_DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && (idx == IDX_W'(g)))
        regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/regbus_rsp_seq.sv
module regbus_rsp_seq
  import regbus_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_fire,
  input  logic                 npw_fire,
  input  logic                 hit,
  input  logic [RB_DATA_W-1:0] rf_rdata,
  output logic                 req_ready,
  output logic                 rd_valid,
  output logic [RB_DATA_W-1:0] rd_data,
  output logic                 wr_done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      wr_done  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      wr_done  <= npw_fire;
      if (rd_fire)
        rd_data <= hit ? rf_rdata : '0;
    end
  end

  // Busy exactly while a response is on the wire.
  assign req_ready = !(rd_valid || wr_done);
endmodule

// File: rtl/regbus_target.sv
module regbus_target
  import regbus_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic        req_write,
  input  logic        req_nposted,
  output logic        rsp_rd_valid,
  output logic [31:0] rsp_rd_data,
  output logic        rsp_wr_done
);
  logic             acc_w, rd_fire_w, pw_fire_w, npw_fire_w, hit_w;
  logic [IDX_W-1:0] idx_w;
  logic [31:0]      rf_rdata_w;
  logic             rf_we_w;

  regbus_req_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_nposted (req_nposted),
    .accept      (acc_w),
    .rd_fire     (rd_fire_w),
    .pw_fire     (pw_fire_w),
    .npw_fire    (npw_fire_w),
    .hit         (hit_w),
    .idx         (idx_w)
  );

  assign rf_we_w = (pw_fire_w || npw_fire_w) && hit_w;

  regbus_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (rf_we_w),
    .idx   (idx_w),
    .wdata (req_wdata),
    .rdata (rf_rdata_w)
  );

  regbus_rsp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire_w),
    .npw_fire  (npw_fire_w),
    .hit       (hit_w),
    .rf_rdata  (rf_rdata_w),
    .req_ready (req_ready),
    .rd_valid  (rsp_rd_valid),
    .rd_data   (rsp_rd_data),
    .wr_done   (rsp_wr_done)
  );
endmodule

// File: rtl/regbus_target_chk.sv
module regbus_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        req_write,
  input logic        req_nposted,
  input logic        rsp_rd_valid,
  input logic [31:0] rsp_rd_data,
  input logic        rsp_wr_done,
  input logic        acc_w,
  input logic        hit_w
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !rsp_rd_valid && !rsp_wr_done));

  a_r3_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && !req_write) |=> (rsp_rd_valid && !req_ready));

  a_r3_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rd_valid |=> !rsp_rd_valid);

  a_r4_posted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && req_write && !req_nposted) |=> (!rsp_wr_done && !rsp_rd_valid && req_ready));

  a_r5_np_done: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && req_write && req_nposted) |=> (rsp_wr_done && !req_ready));

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr_done |=> (!rsp_wr_done && req_ready));

  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rd_valid || rsp_wr_done) |-> !req_ready);

  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && !req_write && !hit_w) |=> (rsp_rd_data == 32'd0));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_rd_valid && rsp_wr_done));

  a_r8_caused: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_w) |=> (!rsp_rd_valid && !rsp_wr_done));
endmodule

bind regbus_target regbus_target_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_nposted  (req_nposted),
  .rsp_rd_valid (rsp_rd_valid),
  .rsp_rd_data  (rsp_rd_data),
  .rsp_wr_done  (rsp_wr_done),
  .acc_w        (acc_w),
  .hit_w        (hit_w)
);

// File: tb/sim_regbus_target.sv
module sim_regbus_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_nposted = 1'b0;
  logic        rsp_rd_valid;
  logic [31:0] rsp_rd_data;
  logic        rsp_wr_done;

  always #2 clk = ~clk;

  regbus_target #(.NUM_REGS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_nposted(req_nposted), .rsp_rd_valid(rsp_rd_valid),
    .rsp_rd_data(rsp_rd_data), .rsp_wr_done(rsp_wr_done)
  );

  typedef struct packed {
    logic        wr;
    logic        np;
    logic [15:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h0000, 32'hA5A5_0001},  // R4 posted
    '{1'b1, 1'b1, 16'h0004, 32'hFFFF_FFFF},  // R5 non-posted
    '{1'b0, 1'b0, 16'h0000, 32'h0},          // R3
    '{1'b0, 1'b1, 16'h0004, 32'h0},          // R3 nposted ignored on read
    '{1'b1, 1'b1, 16'h001C, 32'h8000_0001},  // top register
    '{1'b0, 1'b0, 16'h001C, 32'h0},
    '{1'b1, 1'b0, 16'h0020, 32'hDEAD_BEEF},  // R7 index out of range
    '{1'b0, 1'b0, 16'h0020, 32'h0},          // R7 read zero
    '{1'b1, 1'b1, 16'h0006, 32'h1234_5678},  // R7 misaligned, still completes
    '{1'b0, 1'b0, 16'h0004, 32'h0},          // R9 reg1 untouched
    '{1'b0, 1'b0, 16'hFFFC, 32'h0},          // R7 far address
    '{1'b1, 1'b0, 16'h0008, 32'h0F0F_F0F0},
    '{1'b1, 1'b1, 16'h0008, 32'h3C3C_C3C3},  // overwrite
    '{1'b0, 1'b0, 16'h0008, 32'h0},
    '{1'b0, 1'b0, 16'h000C, 32'h0},          // R1 never written
    '{1'b0, 1'b0, 16'h0000, 32'h0}
  };

  logic [31:0] mdl [8];
  int nchk = 0;
  int nmis = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nmis++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [15:0] a);
    return (a % 4 == 0) && (a < 16'h0020);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
  endtask

  // Issue one request and check the response cycle and the cycle after.
  task automatic do_req(input vec_t v);
    @(negedge clk);
    chk(req_ready === 1'b1, "R6 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = v.wr; req_nposted = v.np;
    req_addr = v.addr; req_wdata = v.data;
    @(negedge clk);
    req_valid = 1'b0;
    if (!v.wr) begin
      chk(rsp_rd_valid === 1'b1, "R3 read valid", 32'(rsp_rd_valid), 32'd1);
      chk(rsp_rd_data === (mapped(v.addr) ? mdl[v.addr[4:2]] : 32'h0),
          "R3/R7 read data", rsp_rd_data,
          mapped(v.addr) ? mdl[v.addr[4:2]] : 32'h0);
      chk(req_ready === 1'b0, "R6 ready low on read resp", 32'(req_ready), 32'd0);
      chk(rsp_wr_done === 1'b0, "R8 no done on read", 32'(rsp_wr_done), 32'd0);
    end else begin
      if (mapped(v.addr)) mdl[v.addr[4:2]] = v.data;
      chk(rsp_wr_done === v.np, "R4/R5 completion", 32'(rsp_wr_done), 32'(v.np));
      chk(req_ready === !v.np, "R4/R5 ready", 32'(req_ready), 32'(!v.np));
      chk(rsp_rd_valid === 1'b0, "R8 no read valid on write", 32'(rsp_rd_valid), 32'd0);
    end
    @(negedge clk);
    chk(!rsp_rd_valid && !rsp_wr_done && req_ready, "R3/R5 single pulse",
        {rsp_rd_valid, rsp_wr_done, req_ready}, 32'b001);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nmis++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nmis);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_rd_valid && !rsp_wr_done, "R1 reset outputs",
        {req_ready, rsp_rd_valid, rsp_wr_done}, 32'b100);

    for (int i = 0; i < NV; i++) do_req(VECS[i]);

    // R2: write offered during the busy cycle of a read must be ignored.
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0010;
    @(negedge clk);
    chk(req_ready === 1'b0, "R2 busy cycle", 32'(req_ready), 32'd0);
    req_write = 1'b1; req_nposted = 1'b1; req_addr = 16'h0014; req_wdata = 32'h7777_7777;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rsp_wr_done, "R2 no completion for refused write", 32'(rsp_wr_done), 32'd0);
    do_req('{1'b0, 1'b0, 16'h0014, 32'h0});

    // R2: same after a non-posted completion cycle.
    do_req('{1'b1, 1'b1, 16'h0018, 32'h0000_0042});
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_nposted = 1'b1;
    req_addr = 16'h0018; req_wdata = 32'h1111_2222;
    @(negedge clk);
    req_write = 1'b0; req_nposted = 1'b0;
    req_addr = 16'h0018;
    @(negedge clk);
    req_valid = 1'b0;
    mdl[6] = 32'h1111_2222;
    chk(rsp_rd_valid === 1'b0, "R2 read refused while done pulse", 32'(rsp_rd_valid), 32'd0);
    do_req('{1'b0, 1'b0, 16'h0018, 32'h0});

    // R1: reset mid-run clears registers.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk(req_ready && !rsp_rd_valid, "R1 after mid reset",
        {req_ready, rsp_rd_valid}, 32'b10);
    do_req('{1'b0, 1'b0, 16'h0008, 32'h0});
    do_req('{1'b0, 1'b0, 16'h0000, 32'h0});

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nmis);
    $finish;
  end
endmodule